// File: doc/BRIEF.md
# Multi-lane byte stream merger

This block sits on the receive side of a striped camera serial link, between per-lane byte alignment and the packet decoder. A packet is spread round-robin across 1, 2 or 4 data lanes. Each lane hands over byte-aligned data with its own valid strobe, plus a start pulse before its first byte and an end pulse with its last byte. The merger holds each lane's bytes in a small queue. Once every active lane has either produced a byte or ended, it reads the queues in lane order and rebuilds the original packet as a single byte stream. The first byte and the last byte of the packet carry markers.

Packets of any length are accepted. When the length is not a multiple of the lane count, the higher lanes carry one byte fewer, and lanes that carry nothing still send a start and an end pulse. The lane count is chosen at run time through a two-bit setting that is held stable during a packet. The aggregate arrival rate may not exceed one byte per clock, which is the rate the merged stream leaves at.

Top module: `lane_merge_top`

## Requirements
- R1: `lane_cfg` selects the active lane count: 0 gives one lane (lane 0), 1 gives two lanes (lanes 0 and 1), and 2 or 3 gives four lanes.
- R2: No byte is emitted for a packet until every active lane has delivered its first byte, or has ended without any byte, after its start pulse.
- R3: Byte k of the merged stream is the byte that lane (k mod N) delivered in round floor(k/N), where N is the active lane count. Lane i carries its data on `lane_byte[8*i+7:8*i]`.
- R4: A packet whose length is not a multiple of N is delivered complete, with no error. This includes lanes that carry no byte (start pulse followed by end pulse).
- R5: `out_first` is high with the first emitted byte of a packet only. `out_last` is high with the final byte only. Both are qualified by `out_valid`.
- R6: Inputs on lanes above the active count have no effect on the merged stream or on the error flag.
- R7: `order_err` pulses for one cycle, one clock after lane i accepts its end pulse, if any lower active lane has already ended, or ends in the same cycle, with fewer bytes than lane i.
- R8: While reset is low, and after it is released with idle inputs, `out_valid`, `out_first`, `out_last` and `order_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lane_cfg | input | 2 | Active lane count select |
| lane_sot | input | 4 | Per-lane start-of-transmission pulse |
| lane_valid | input | 4 | Per-lane byte strobe |
| lane_byte | input | 32 | Per-lane byte, lane i in bits 8i+7:8i |
| lane_eot | input | 4 | Per-lane end-of-transmission, with or after the last byte |
| out_valid | output | 1 | Merged byte valid |
| out_byte | output | 8 | Merged byte |
| out_first | output | 1 | First byte of packet |
| out_last | output | 1 | Last byte of packet |
| order_err | output | 1 | Lane end-order violation pulse |

## Verification
The hardest situation to reach is the end of a packet while the lanes are still out of step. In that case the last byte sits in a low lane and the higher lanes have already finished one round earlier, possibly with nothing at all. A fault there shows up as a lost byte, a premature last marker or a spurious error. The stimulus gives each lane an independent start delay of up to two clocks. It paces every lane at one byte per N clocks, and sweeps lengths from 1 to 64 across all three lane counts, both from a table of chosen cases and from random draws. A hand-built packet with a short low lane provokes the order error.

// File: rtl/lane_merge_pkg.sv
// Shared helpers for the lane merger.
// Assumes the lane-count select is a two-bit code; any code above 1 means four lanes.
package lane_merge_pkg;

    localparam int BYTE_W = 8;

    // Decode the lane-count select into a lane count.
    function automatic logic [2:0] lanes_of(input logic [1:0] cfg);
        case (cfg)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/lane_byte_fifo.sv
// Small per-lane byte queue that absorbs inter-lane skew.
// Assumes DEPTH is a power of two. Writers never push when full and readers never pop when empty.
// A synchronous flush empties the queue at packet end.
module lane_byte_fifo #(
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [7:0]    din,
    input  logic          pop,
    output logic [7:0]    dout,
    output logic [CW-1:0] count
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic          push_ok;

    assign push_ok = push && (count != CW'(DEPTH));
    assign dout    = mem[rp];

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= wp + AW'(1);
            if (pop)     rp <= rp + AW'(1);
            count <= count + CW'(push_ok) - CW'(pop);
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != CW'(DEPTH)));

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

endmodule

// File: rtl/lane_rx_track.sv
// Per-lane packet tracker. It opens on a start pulse and accepts bytes while open.
// It closes on the end pulse and counts accepted bytes.
// Assumes the end pulse arrives with or after the lane's last byte. Clear restarts it for the next packet.
module lane_rx_track #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic             sot,
    input  logic             valid,
    input  logic             eot,
    output logic             push,
    output logic             eot_now,
    output logic             done,
    output logic [CNT_W-1:0] nbytes,
    output logic [CNT_W-1:0] nbytes_next
);

    logic seen;
    logic open_now;

    assign open_now    = active && (seen || sot) && !done;
    assign push        = open_now && valid;
    assign eot_now     = open_now && eot;
    assign nbytes_next = nbytes + CNT_W'(push);

    // Track start, end and byte count for the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            seen   <= 1'b0;
            done   <= 1'b0;
            nbytes <= '0;
        end else begin
            if (open_now) seen <= 1'b1;
            if (push)     nbytes <= nbytes_next;
            if (eot_now)  done <= 1'b1;
        end
    end

    assert_end_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear) |=> done);

endmodule

// File: rtl/merge_sequencer.sv
// Round-robin reader over the lane queues.
// It waits until every active lane is ready, then pops lanes in index order.
// Before popping, it looks one lane ahead so that the final byte can be flagged.
// Assumes the lane count is 1, 2 or 4 and is stable within a packet.
module merge_sequencer #(
    parameter int MAX_LANES = 4,
    parameter int CW = 3,
    localparam int LW = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2:0]                    n_lanes,
    input  logic [MAX_LANES-1:0][CW-1:0]  fcnt,
    input  logic [MAX_LANES-1:0]          done,
    input  logic [MAX_LANES-1:0][7:0]     heads,
    output logic [MAX_LANES-1:0]          pop_vec,
    output logic                          pkt_end,
    output logic                          out_valid,
    output logic [7:0]                    out_byte,
    output logic                          out_first,
    output logic                          out_last
);

    logic [MAX_LANES-1:0] ready;
    logic [MAX_LANES-1:0] fin;
    logic                 armed;
    logic                 all_done;
    logic                 running;
    logic                 first_pending;
    logic [LW-1:0]        ptr;
    logic [LW-1:0]        nxt;
    logic [LW-1:0]        mask;
    logic                 cur_has;
    logic                 nxt_more;
    logic                 nxt_end;
    logic                 pop;
    logic                 last;
    logic                 empty_end;

    // Per-lane readiness and completion, inactive lanes count as both.
    always_comb begin
        for (int i = 0; i < MAX_LANES; i++) begin
            ready[i] = (i >= int'(n_lanes)) || (fcnt[i] != '0) || done[i];
            fin[i]   = (i >= int'(n_lanes)) || done[i];
        end
    end

    assign armed     = &ready;
    assign all_done  = &fin;
    assign mask      = LW'(n_lanes - 3'd1);
    assign nxt       = (ptr + LW'(1)) & mask;
    assign cur_has   = (fcnt[ptr] != '0);
    assign nxt_more  = (nxt == ptr) ? (fcnt[nxt] >= CW'(2)) : (fcnt[nxt] != '0);
    assign nxt_end   = done[nxt] && !nxt_more && all_done;
    assign pop       = running && cur_has && (nxt_more || nxt_end);
    assign last      = pop && nxt_end;
    assign empty_end = running && !cur_has && done[ptr] && all_done;
    assign pkt_end   = last || empty_end;

    // One-hot pop request to the lane under the pointer.
    always_comb begin
        pop_vec = '0;
        if (pop) pop_vec[ptr] = 1'b1;
    end

    // Packet run state, lane pointer and first-byte marker.
    always_ff @(posedge clk) begin
        if (!rst_n || pkt_end) begin
            running       <= 1'b0;
            ptr           <= '0;
            first_pending <= 1'b1;
        end else begin
            if (armed) running <= 1'b1;
            if (pop) begin
                ptr           <= nxt;
                first_pending <= 1'b0;
            end
        end
    end

    // Registered merged output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= pop;
            out_byte  <= heads[ptr];
            out_first <= pop && first_pending;
            out_last  <= last;
        end
    end

    assert_ptr_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) < int'(n_lanes));

    assert_start_after_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(armed));

    assert_first_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> out_valid);

    assert_last_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

endmodule

// File: rtl/lane_merge_top.sv
// Multi-lane byte stream merger.
// Each lane has a tracker and a skew queue. A round-robin sequencer rebuilds the packet order.
// A lane-order checker flags ends that break the striping pattern.
// Assumes the aggregate byte rate is at most one per clock and lane_cfg is stable within a packet.
module lane_merge_top
    import lane_merge_pkg::*;
#(
    parameter int MAX_LANES  = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 8,
    localparam int FCW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  lane_cfg,
    input  logic [MAX_LANES-1:0]        lane_sot,
    input  logic [MAX_LANES-1:0]        lane_valid,
    input  logic [MAX_LANES*BYTE_W-1:0] lane_byte,
    input  logic [MAX_LANES-1:0]        lane_eot,
    output logic                        out_valid,
    output logic [7:0]                  out_byte,
    output logic                        out_first,
    output logic                        out_last,
    output logic                        order_err
);

    logic [2:0]                      n_sel;
    logic [2:0]                      n_lanes;
    logic [MAX_LANES-1:0]            lane_act;
    logic [MAX_LANES-1:0]            push;
    logic [MAX_LANES-1:0]            eot_now;
    logic [MAX_LANES-1:0]            done;
    logic [MAX_LANES-1:0][CNT_W-1:0] nbytes;
    logic [MAX_LANES-1:0][CNT_W-1:0] nbytes_next;
    logic [MAX_LANES-1:0][FCW-1:0]   fcnt;
    logic [MAX_LANES-1:0][7:0]       heads;
    logic [MAX_LANES-1:0]            pop_vec;
    logic                            pkt_end;
    logic                            viol;

    assign n_sel   = lanes_of(lane_cfg);
    assign n_lanes = (int'(n_sel) > MAX_LANES) ? 3'(MAX_LANES) : n_sel;

    // Active-lane mask from the lane count.
    always_comb begin
        for (int i = 0; i < MAX_LANES; i++) lane_act[i] = (i < int'(n_lanes));
    end

    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
        lane_rx_track #(.CNT_W(CNT_W)) u_trk (
            .clk         (clk),
            .rst_n       (rst_n),
            .clear       (pkt_end),
            .active      (lane_act[g]),
            .sot         (lane_sot[g]),
            .valid       (lane_valid[g]),
            .eot         (lane_eot[g]),
            .push        (push[g]),
            .eot_now     (eot_now[g]),
            .done        (done[g]),
            .nbytes      (nbytes[g]),
            .nbytes_next (nbytes_next[g])
        );

        lane_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (pkt_end),
            .push  (push[g]),
            .din   (lane_byte[g*BYTE_W +: BYTE_W]),
            .pop   (pop_vec[g]),
            .dout  (heads[g]),
            .count (fcnt[g])
        );

        assert_idle_lane_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_act[g] |-> (fcnt[g] == '0));
    end

    merge_sequencer #(.MAX_LANES(MAX_LANES), .CW(FCW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .n_lanes   (n_lanes),
        .fcnt      (fcnt),
        .done      (done),
        .heads     (heads),
        .pop_vec   (pop_vec),
        .pkt_end   (pkt_end),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .out_first (out_first),
        .out_last  (out_last)
    );

    // Lane-order check: a lower lane closed with fewer bytes than a lane closing now.
    always_comb begin
        viol = 1'b0;
        for (int i = 1; i < MAX_LANES; i++) begin
            for (int j = 0; j < MAX_LANES; j++) begin
                if (j < i && eot_now[i] && (done[j] || eot_now[j]) &&
                    (nbytes_next[j] < nbytes_next[i])) viol = 1'b1;
            end
        end
    end

    // Register the order error as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) order_err <= 1'b0;
        else        order_err <= viol;
    end

    assert_err_needs_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |-> ($past(eot_now) != '0));

endmodule

// File: tb/tb_lane_merge_top.sv
`timescale 1ns/1ps
module tb_lane_merge_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  lane_cfg;
    logic [3:0]  lane_sot;
    logic [3:0]  lane_valid;
    logic [31:0] lane_byte;
    logic [3:0]  lane_eot;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic        out_first;
    logic        out_last;
    logic        order_err;

    always #2.5 clk = ~clk;

    lane_merge_top dut (
        .clk(clk), .rst_n(rst_n), .lane_cfg(lane_cfg), .lane_sot(lane_sot),
        .lane_valid(lane_valid), .lane_byte(lane_byte), .lane_eot(lane_eot),
        .out_valid(out_valid), .out_byte(out_byte), .out_first(out_first),
        .out_last(out_last), .order_err(order_err)
    );

    int checks = 0;
    int fails  = 0;
    int pe     = 0;
    bit finished = 0;

    logic [7:0] cap_b [64];
    bit         cap_f [64];
    bit         cap_l [64];
    int         cap_n;
    int         first_pe;
    bit         err_seen;

    // Vector table: lane select, length, per-lane start delay (nibble per lane), idle-lane noise.
    localparam int NV = 12;
    localparam int V_CFG  [NV] = '{0, 0, 1, 1, 1, 1, 2, 2, 2, 2, 2, 2};
    localparam int V_LEN  [NV] = '{1, 7, 1, 2, 9, 16, 1, 3, 4, 5, 63, 64};
    localparam int V_SKEW [NV] = '{0, 0, 'h00, 'h10, 'h01, 'h10, 0, 'h2100, 'h0120, 'h1002, 'h2010, 'h0000};
    localparam int V_NOISE[NV] = '{0, 1, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0};

    always @(posedge clk) pe <= pe + 1;

    // Capture the merged stream away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (cap_n < 64) begin
                cap_b[cap_n] = out_byte;
                cap_f[cap_n] = out_first;
                cap_l[cap_n] = out_last;
            end
            if (first_pe < 0) first_pe = pe;
            cap_n = cap_n + 1;
        end
        if (rst_n && order_err) err_seen = 1;
    end

    function automatic logic [7:0] pat(input int tag, input int k);
        return 8'((tag * 37 + k * 11 + 5) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lane_sot = '0; lane_valid = '0; lane_eot = '0; lane_byte = '0;
    endtask

    task automatic run_packet(input int cfg, input int len, input int skw,
                              input bit noise, input int tag);
        int n;
        int cnt [4];
        int st  [4];
        int max_first;
        int last_c;
        int base;
        bit ok;
        int bad_k;
        n = (cfg == 0) ? 1 : (cfg == 1) ? 2 : 4;
        max_first = 0;
        last_c = 0;
        for (int i = 0; i < 4; i++) begin
            st[i]  = (skw >> (4 * i)) & 15;
            cnt[i] = (i < n && i < len) ? (len - i + n - 1) / n : 0;
            if (i < n) begin
                if (st[i] + 2 > max_first) max_first = st[i] + 2;
                if (st[i] + 1 + ((cnt[i] > 0) ? (cnt[i] - 1) * n : 0) > last_c)
                    last_c = st[i] + 1 + ((cnt[i] > 0) ? (cnt[i] - 1) * n : 0);
            end
        end
        @(negedge clk);
        lane_cfg = 2'(cfg);
        cap_n = 0; first_pe = -1; err_seen = 0;
        base = pe;
        for (int c = 0; c <= last_c + 1; c++) begin
            idle_inputs();
            for (int i = 0; i < 4; i++) begin
                int rel;
                rel = c - st[i] - 1;
                if (i < n) begin
                    lane_sot[i] = (c == st[i]);
                    if (cnt[i] > 0) begin
                        if (rel >= 0 && rel % n == 0 && rel / n < cnt[i]) begin
                            lane_valid[i] = 1'b1;
                            lane_byte[i*8 +: 8] = pat(tag, i + (rel / n) * n);
                            lane_eot[i] = (rel / n == cnt[i] - 1);
                        end
                    end else begin
                        lane_eot[i] = (rel == 0);
                    end
                end else if (noise) begin
                    lane_sot[i]   = (c == 0);
                    lane_valid[i] = 1'b1;
                    lane_byte[i*8 +: 8] = 8'hA5;
                    lane_eot[i]   = (c == 3);
                end
            end
            @(negedge clk);
        end
        idle_inputs();
        repeat (24) @(negedge clk);

        // R3 / R4: complete packet in original order (R6 when idle lanes are noisy).
        ok = (cap_n == len);
        bad_k = -1;
        for (int k = 0; k < len && k < 64; k++)
            if (ok && cap_b[k] != pat(tag, k)) begin ok = 0; bad_k = k; end
        if (bad_k >= 0)
            check(0, noise ? "R3/R6" : "R3", $sformatf("byte %0d lanes %0d len %0d", bad_k, n, len),
                  cap_b[bad_k], pat(tag, bad_k));
        else
            check(ok, (len % n != 0) ? "R4" : "R3", $sformatf("byte count lanes %0d len %0d", n, len),
                  cap_n, len);
        // R5: first and last markers.
        ok = 1;
        for (int k = 0; k < cap_n && k < 64; k++)
            if (cap_f[k] != (k == 0) || cap_l[k] != (k == len - 1)) ok = 0;
        check(ok, "R5", $sformatf("markers lanes %0d len %0d", n, len), ok, 1);
        // R2: nothing emitted before the slowest active lane delivered.
        check(first_pe > base + max_first, "R2", $sformatf("first output edge lanes %0d len %0d", n, len),
              first_pe - base, max_first + 1);
        // R4 / R1: legal striping raises no order error.
        check(!err_seen, "R4", $sformatf("no order error lanes %0d len %0d", n, len), err_seen, 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cap_n = 0; first_pe = -1; err_seen = 0;
        rst_n = 1'b0;
        lane_cfg = 2'd2;
        // R8: noise during reset must leave outputs quiet.
        lane_sot = 4'hF; lane_valid = 4'hF; lane_byte = 32'h12345678; lane_eot = '0;
        repeat (3) @(negedge clk);
        check(!out_valid && !out_first && !out_last && !order_err, "R8", "outputs in reset",
              {out_valid, out_first, out_last, order_err}, 0);
        idle_inputs();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(cap_n == 0 && !err_seen, "R8", "quiet after reset release", cap_n, 0);

        // Table walk: R1 across all lane counts.
        for (int v = 0; v < NV; v++)
            run_packet(V_CFG[v], V_LEN[v], V_SKEW[v], V_NOISE[v] != 0, v + 1);

        // Select code 3 also means four lanes (R1).
        run_packet(3, 10, 'h0201, 0, 50);

        // R7: lane 0 ends after one byte, lane 1 ends later after two.
        @(negedge clk);
        lane_cfg = 2'd1; cap_n = 0; first_pe = -1; err_seen = 0;
        idle_inputs(); lane_sot = 4'b0011;
        @(negedge clk);
        idle_inputs(); lane_valid = 4'b0011; lane_eot = 4'b0001; lane_byte = 32'h0000_2211;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        idle_inputs(); lane_valid = 4'b0010; lane_eot = 4'b0010; lane_byte = 32'h0000_3300;
        @(negedge clk);
        idle_inputs();
        repeat (20) @(negedge clk);
        check(err_seen, "R7", "order error raised", err_seen, 1);

        // Random packets across all lane counts.
        for (int r = 0; r < 36; r++) begin
            int cfg;
            int len;
            int skw;
            cfg = $urandom % 3;
            len = 1 + ($urandom % 64);
            skw = ($urandom % 3) | (($urandom % 3) << 4) | (($urandom % 3) << 8) | (($urandom % 3) << 12);
            run_packet(cfg, len, skw, ($urandom % 2) == 1, 100 + r);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule